// File: doc/BRIEF.md
# Display Power-Up Command Sequencer

This block brings a display controller out of reset by replaying a built-in start-up script through a byte-wide serial writer. One `start` pulse walks the whole script. Each script step sends one opcode byte and then zero to fifteen argument bytes. A step can also ask for a pause of several milliseconds before the next step begins. The block offers every byte to the writer with a valid/ready handshake, and it marks each byte as either an opcode or an argument. The writer turns that flag into its command/data select line.

The script is fixed when the chip is built. It is stored as a step table (opcode, argument count, pause selector, end mark) plus two argument byte pools: one for the two fifteen-byte gamma curves and one for all the other arguments. Pause lengths are counted in system clock cycles. A parameter gives the number of cycles in one millisecond, so a bench can use a short time base. While the script runs, `busy` is high. When the last opcode has been accepted, `done` pulses once.

Top module: `disp_init_seq`

## Requirements
- R1: While reset is asserted and after reset is released, `busy`, `done` and `wrValid` are all low until `start` is seen.
- R2: A `start` seen while idle makes `busy` high on the next cycle and begins the script from its first step. A `start` seen while `busy` is high does not change the byte stream, and it does not cause a second `done`.
- R3: Every opcode byte is offered with `wrIsData` = 0, and every argument byte is offered with `wrIsData` = 1.
- R4: The accepted bytes are, in order: the 23 opcodes of the script, each followed by its own argument bytes. Argument counts range from 0 to 15, with 15 for each of the gamma opcodes 0xE0 and 0xE1. A run accepts exactly 88 bytes.
- R5: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrByte` and `wrIsData` stay unchanged into the next cycle.
- R6: After the argument of the pixel-format opcode 0x3A, and again after the argument of the interface-control opcode 0xB0, `wrValid` stays low for at least 20×CYC_PER_MS cycles. Between all other bytes in a run, no cycle has `wrValid` low.
- R7: The script ends with opcode 0x11, then a pause of at least 12×CYC_PER_MS cycles with `wrValid` low, then opcode 0x29, then opcode 0x2C. None of these three opcodes carries arguments.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the handshake of the final byte, and `busy` is low in it.
- R9: Opcode 0x3A is followed by the single argument 0x66, and opcode 0x36 is followed by the single argument 0xC8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to play the script; only acted on while idle |
| wrReady | input | 1 | Writer can accept the offered byte this cycle |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| wrValid | output | 1 | A byte is offered to the writer |
| wrByte | output | 8 | Offered opcode or argument byte |
| wrIsData | output | 1 | 0 for an opcode byte, 1 for an argument byte |

## Verification
The handshake-hold property assumes that the writer may hold `wrReady` low for any number of cycles but never takes back a byte it has accepted. The bench drives `wrReady` on its own from a seeded random source: always high, about half the time, and about a quarter of the time. The start-response property assumes `start` is a plain level that is sampled each cycle. The bench raises it for single cycles, one of them deliberately in the middle of a run. The pause properties assume that the cycles-per-millisecond parameter is at least one, and the bench uses a value of five.

// File: rtl/disp_init_pkg.sv
package disp_init_pkg;

  localparam int SCRIPT_LEN  = 24;  // 23 steps plus end mark
  localparam int PARAM_TOTAL = 65;
  localparam int GAMMA_BASE  = 30;
  localparam int GAMMA_LEN   = 30;
  localparam int GEN_LEN     = PARAM_TOTAL - GAMMA_LEN;
  localparam int IDX_W       = $clog2(SCRIPT_LEN + 1);
  localparam int PTR_W       = $clog2(PARAM_TOTAL + 1);
  localparam int CNT_W       = 4;
  localparam int SHORT_MS    = 12;
  localparam int LONG_MS     = 20;

  typedef enum logic [1:0] {WAIT_NONE, WAIT_SHORT, WAIT_LONG} waitSel_e;

  typedef struct packed {
    logic [7:0]       op;
    logic [CNT_W-1:0] nPar;
    waitSel_e         waitSel;
    logic             isEnd;
  } entry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;
    logic step;
    logic loadWait;
    logic tick;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic [7:0] byteOut;
    logic       isData;
    logic       lastOfEntry;
    logic       needWait;
    logic       nextIsEnd;
    logic       curIsEnd;
    logic       waitDone;
    logic       waitActive;
  } dpStat_t;

  localparam entry_t SCRIPT [SCRIPT_LEN] = '{
    '{8'hCF, 4'd3,  WAIT_NONE,  1'b0},
    '{8'hED, 4'd4,  WAIT_NONE,  1'b0},
    '{8'hE8, 4'd3,  WAIT_NONE,  1'b0},
    '{8'hCB, 4'd5,  WAIT_NONE,  1'b0},
    '{8'hF7, 4'd1,  WAIT_NONE,  1'b0},
    '{8'hEA, 4'd2,  WAIT_NONE,  1'b0},
    '{8'hB1, 4'd2,  WAIT_NONE,  1'b0},
    '{8'hB6, 4'd2,  WAIT_NONE,  1'b0},
    '{8'hC0, 4'd1,  WAIT_NONE,  1'b0},
    '{8'hC1, 4'd1,  WAIT_NONE,  1'b0},
    '{8'hC5, 4'd2,  WAIT_NONE,  1'b0},
    '{8'hC7, 4'd1,  WAIT_NONE,  1'b0},
    '{8'h36, 4'd1,  WAIT_NONE,  1'b0},
    '{8'hF2, 4'd1,  WAIT_NONE,  1'b0},
    '{8'h26, 4'd1,  WAIT_NONE,  1'b0},
    '{8'hE0, 4'd15, WAIT_NONE,  1'b0},
    '{8'hE1, 4'd15, WAIT_NONE,  1'b0},
    '{8'h3A, 4'd1,  WAIT_LONG,  1'b0},
    '{8'hB0, 4'd1,  WAIT_LONG,  1'b0},
    '{8'hF6, 4'd3,  WAIT_NONE,  1'b0},
    '{8'h11, 4'd0,  WAIT_SHORT, 1'b0},
    '{8'h29, 4'd0,  WAIT_NONE,  1'b0},
    '{8'h2C, 4'd0,  WAIT_NONE,  1'b0},
    '{8'h00, 4'd0,  WAIT_NONE,  1'b1}
  };

  // arguments of every step except the gamma curves, in script order
  localparam logic [7:0] GEN_BYTES [GEN_LEN] = '{
    8'h00, 8'hC1, 8'h30,
    8'h64, 8'h03, 8'h12, 8'h81,
    8'h85, 8'h10, 8'h7A,
    8'h39, 8'h2C, 8'h00, 8'h34, 8'h02,
    8'h20,
    8'h00, 8'h00,
    8'h00, 8'h1A,
    8'h0A, 8'hA2,
    8'h1B,
    8'h01,
    8'h30, 8'h30,
    8'hB7,
    8'hC8,
    8'h00,
    8'h01,
    8'h66,
    8'hCC,
    8'h00, 8'h30, 8'h06
  };

  // positive then negative gamma curve
  localparam logic [7:0] GAMMA_BYTES [GAMMA_LEN] = '{
    8'h0F, 8'h2A, 8'h28, 8'h08, 8'h0E, 8'h08, 8'h54, 8'hA9,
    8'h43, 8'h0A, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h15, 8'h17, 8'h07, 8'h11, 8'h06, 8'h2B, 8'h56,
    8'h3C, 8'h05, 8'h10, 8'h0F, 8'h3F, 8'h3F, 8'h0F
  };

  function automatic entry_t entryAt(input logic [IDX_W-1:0] idx);
    entry_t e;
    if (int'(idx) >= SCRIPT_LEN) e = '{8'h00, 4'd0, WAIT_NONE, 1'b1};
    else                         e = SCRIPT[idx];
    return e;
  endfunction

  function automatic logic isEndAt(input logic [IDX_W-1:0] idx);
    entry_t e;
    e = entryAt(idx);
    return e.isEnd;
  endfunction

  function automatic logic [7:0] paramAt(input logic [PTR_W-1:0] ptr);
    int pi;
    logic [7:0] b;
    pi = int'(ptr);
    if (pi >= GAMMA_BASE && pi < GAMMA_BASE + GAMMA_LEN) b = GAMMA_BYTES[pi - GAMMA_BASE];
    else if (pi < GAMMA_BASE)                             b = GEN_BYTES[pi];
    else if (pi < PARAM_TOTAL)                            b = GEN_BYTES[pi - GAMMA_LEN];
    else                                                  b = 8'h00;
    return b;
  endfunction

endpackage

// File: rtl/disp_init_dp.sv
module disp_init_dp
  import disp_init_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output dpStat_t stat
);

  localparam int LONG_CYC_I  = LONG_MS * CYC_PER_MS;
  localparam int SHORT_CYC_I = SHORT_MS * CYC_PER_MS;
  localparam int WAIT_W      = $clog2(LONG_CYC_I + 1);
  localparam logic [WAIT_W-1:0] LONG_CYC  = WAIT_W'(LONG_CYC_I);
  localparam logic [WAIT_W-1:0] SHORT_CYC = WAIT_W'(SHORT_CYC_I);

  logic [IDX_W-1:0]  entryIdx;
  logic [PTR_W-1:0]  parPtr;
  logic [CNT_W-1:0]  remain;
  logic              inParams;
  logic [WAIT_W-1:0] waitCnt;
  entry_t            cur;

  assign cur = entryAt(entryIdx);

  always_comb begin
    stat.byteOut     = inParams ? paramAt(parPtr) : cur.op;
    stat.isData      = inParams;
    stat.lastOfEntry = inParams ? (remain == CNT_W'(1)) : (cur.nPar == '0);
    stat.needWait    = (cur.waitSel != WAIT_NONE);
    stat.nextIsEnd   = isEndAt(entryIdx + 1'b1);
    stat.curIsEnd    = cur.isEnd;
    stat.waitDone    = (waitCnt == WAIT_W'(1));
    stat.waitActive  = (waitCnt != '0);
  end

  // script position: step index, argument pointer, arguments left
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryIdx <= '0;
      parPtr   <= '0;
      remain   <= '0;
      inParams <= 1'b0;
    end else if (stb.clear) begin
      entryIdx <= '0;
      parPtr   <= '0;
      remain   <= '0;
      inParams <= 1'b0;
    end else if (stb.step) begin
      if (inParams) begin
        parPtr <= parPtr + 1'b1;
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) begin
          inParams <= 1'b0;
          entryIdx <= entryIdx + 1'b1;
        end
      end else if (cur.nPar != '0) begin
        inParams <= 1'b1;
        remain   <= cur.nPar;
      end else begin
        entryIdx <= entryIdx + 1'b1;
      end
    end
  end

  // pause counter in system clock cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          waitCnt <= '0;
    else if (stb.clear)                 waitCnt <= '0;
    else if (stb.loadWait)              waitCnt <= (cur.waitSel == WAIT_LONG) ? LONG_CYC : SHORT_CYC;
    else if (stb.tick && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end

  // R4: argument pointer never runs past the pools
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(parPtr) <= PARAM_TOTAL);

  // R4: while sending arguments at least one is left
  p_remain_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    inParams |-> remain != '0);

  // R6: a loaded pause starts non-zero
  p_wait_loaded_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadWait |=> waitCnt != '0);

endmodule

// File: rtl/disp_init_ctrl.sv
module disp_init_ctrl
  import disp_init_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    wrReady,
  input  dpStat_t stat,
  output strobe_t stb,
  output logic    busy,
  output logic    done,
  output logic    wrValid
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_e;

  state_e state, stateNxt;
  logic   hs;
  logic   finishing;

  assign hs = (state == S_SEND) && wrReady;

  always_comb begin
    stb.clear    = (state == S_IDLE) && start;
    stb.step     = hs;
    stb.loadWait = hs && stat.lastOfEntry && stat.needWait;
    stb.tick     = (state == S_WAIT);
  end

  always_comb begin
    stateNxt  = state;
    finishing = 1'b0;
    unique case (state)
      S_IDLE: if (start) stateNxt = S_SEND;
      S_SEND: if (hs && stat.lastOfEntry) begin
        if (stat.needWait) stateNxt = S_WAIT;
        else if (stat.nextIsEnd) begin
          stateNxt  = S_IDLE;
          finishing = 1'b1;
        end
      end
      S_WAIT: if (stat.waitDone) begin
        if (stat.curIsEnd) begin
          stateNxt  = S_IDLE;
          finishing = 1'b1;
        end else stateNxt = S_SEND;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= finishing;
    end
  end

  assign busy    = (state != S_IDLE);
  assign wrValid = (state == S_SEND);

  // R5: offered byte held until accepted
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(stat.byteOut) && $stable(stat.isData));

  // R6: nothing offered while a pause runs
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    stat.waitActive |-> !wrValid);

  // R2: start while idle is taken
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  // R8: single-cycle done, only when idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
  import disp_init_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrReady,
  output logic       busy,
  output logic       done,
  output logic       wrValid,
  output logic [7:0] wrByte,
  output logic       wrIsData
);

  strobe_t stb;
  dpStat_t stat;

  disp_init_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .wrReady (wrReady),
    .stat    (stat),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .wrValid (wrValid)
  );

  disp_init_dp #(.CYC_PER_MS(CYC_PER_MS)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .stat (stat)
  );

  assign wrByte   = stat.byteOut;
  assign wrIsData = stat.isData;

endmodule

// File: tb/tb_disp_init_seq.sv
module tb_disp_init_seq;

  localparam int CPM     = 5;
  localparam int N_STEP  = 23;
  localparam int N_BYTES = 88;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, wrReady = 1'b0;
  logic busy, done, wrValid, wrIsData;
  logic [7:0] wrByte;

  always #10 clk = ~clk;

  disp_init_seq #(.CYC_PER_MS(CPM)) dut (
    .clk(clk), .rstN(rstN), .start(start), .wrReady(wrReady),
    .busy(busy), .done(done), .wrValid(wrValid), .wrByte(wrByte), .wrIsData(wrIsData)
  );

  localparam logic [7:0] STEP_OP [N_STEP] = '{
    8'hCF, 8'hED, 8'hE8, 8'hCB, 8'hF7, 8'hEA, 8'hB1, 8'hB6, 8'hC0, 8'hC1, 8'hC5, 8'hC7,
    8'h36, 8'hF2, 8'h26, 8'hE0, 8'hE1, 8'h3A, 8'hB0, 8'hF6, 8'h11, 8'h29, 8'h2C};
  localparam int STEP_CNT [N_STEP] = '{
    3, 4, 3, 5, 1, 2, 2, 2, 1, 1, 2, 1, 1, 1, 1, 15, 15, 1, 1, 3, 0, 0, 0};
  localparam int STEP_MS [N_STEP] = '{
    0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 20, 20, 0, 12, 0, 0};
  localparam logic [7:0] ARG_MAIN [35] = '{
    8'h00, 8'hC1, 8'h30, 8'h64, 8'h03, 8'h12, 8'h81, 8'h85, 8'h10, 8'h7A,
    8'h39, 8'h2C, 8'h00, 8'h34, 8'h02, 8'h20, 8'h00, 8'h00, 8'h00, 8'h1A,
    8'h0A, 8'hA2, 8'h1B, 8'h01, 8'h30, 8'h30, 8'hB7, 8'hC8, 8'h00, 8'h01,
    8'h66, 8'hCC, 8'h00, 8'h30, 8'h06};
  localparam logic [7:0] ARG_GAMMA [30] = '{
    8'h0F, 8'h2A, 8'h28, 8'h08, 8'h0E, 8'h08, 8'h54, 8'hA9, 8'h43, 8'h0A,
    8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h15, 8'h17, 8'h07, 8'h11,
    8'h06, 8'h2B, 8'h56, 8'h3C, 8'h05, 8'h10, 8'h0F, 8'h3F, 8'h3F, 8'h0F};

  logic [7:0] seqByte [N_BYTES];
  logic       seqData [N_BYTES];
  int         seqMs   [N_BYTES];

  int checks = 0, fails = 0;
  int k = 0, gap = 0, doneCnt = 0;
  bit expectDone = 0;
  int readyMode = 0;
  logic [7:0] prevByte = 8'h00;
  logic       prevData = 1'b1;

  function automatic logic [7:0] argOf(input int p);
    if (p < 30)      return ARG_MAIN[p];
    else if (p < 60) return ARG_GAMMA[p - 30];
    else             return ARG_MAIN[p - 30];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // writer model: ready changes just after each rising edge
  initial begin
    void'($urandom(32'h5EED_0042));
    forever begin
      @(posedge clk);
      #1;
      case (readyMode)
        0:       wrReady = 1'b1;
        1:       wrReady = ($urandom % 2) == 0;
        default: wrReady = ($urandom % 4) == 0;
      endcase
    end
  end

  // monitor: decodes every accepted byte at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (start && !busy) begin
          k = 0; gap = 0; expectDone = 0; doneCnt = 0;
        end
        if (expectDone) begin
          chk(done == 1'b1, "R8", "done after final byte", done, 1);
          chk(busy == 1'b0, "R8", "busy with done", busy, 0);
          expectDone = 0;
          if (done) doneCnt++;
        end else if (done) begin
          chk(1'b0, "R8", "stray done", done, 0);
          doneCnt++;
        end
        if (wrValid && wrReady) begin
          if (k >= N_BYTES) chk(1'b0, "R4", "extra byte", k, N_BYTES);
          else begin
            chk(wrIsData == seqData[k], "R3", "opcode/argument flag", wrIsData, seqData[k]);
            chk(wrByte == seqByte[k], "R4", "byte value", wrByte, seqByte[k]);
            if (k > 0) begin
              if (seqMs[k-1] == 12)
                chk(gap >= seqMs[k-1] * CPM, "R7", "sleep-exit pause", gap, seqMs[k-1] * CPM);
              else if (seqMs[k-1] > 0)
                chk(gap >= seqMs[k-1] * CPM, "R6", "long pause", gap, seqMs[k-1] * CPM);
              else
                chk(gap == 0, "R6", "idle gap without pause", gap, 0);
            end
            if (!prevData && prevByte == 8'h3A)
              chk(wrIsData && wrByte == 8'h66, "R9", "pixel-format argument", wrByte, 8'h66);
            if (!prevData && prevByte == 8'h36)
              chk(wrIsData && wrByte == 8'hC8, "R9", "access-control argument", wrByte, 8'hC8);
            prevByte = wrByte;
            prevData = wrIsData;
            k++;
            gap = 0;
            if (k == N_BYTES) expectDone = 1;
          end
        end else if (busy && !wrValid) gap++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual %0h expected %0h", 0, 1);
    finishRun();
  end

  task automatic runOnce(input int mode, input bit poke);
    readyMode = mode;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (poke) begin
      wait (k >= 40);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    wait (doneCnt >= 1);
    repeat (6) @(negedge clk);
    chk(doneCnt == 1, "R2", "done count per run", doneCnt, 1);
    chk(k == N_BYTES, "R4", "bytes per run", k, N_BYTES);
    chk(busy == 1'b0 && wrValid == 1'b0, "R2", "idle after run", busy, 0);
  endtask

  initial begin
    int n = 0, p = 0;
    for (int s = 0; s < N_STEP; s++) begin
      seqByte[n] = STEP_OP[s];
      seqData[n] = 1'b0;
      seqMs[n]   = (STEP_CNT[s] == 0) ? STEP_MS[s] : 0;
      n++;
      for (int j = 0; j < STEP_CNT[s]; j++) begin
        seqByte[n] = argOf(p);
        seqData[n] = 1'b1;
        seqMs[n]   = (j == STEP_CNT[s] - 1) ? STEP_MS[s] : 0;
        n++; p++;
      end
    end
    chk(n == N_BYTES, "R4", "expected stream length", n, N_BYTES);

    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && wrValid == 1'b0, "R1", "outputs in reset",
        {busy, done, wrValid}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && wrValid == 1'b0, "R1", "outputs after reset",
        {busy, done, wrValid}, 0);

    runOnce(0, 1'b0);
    runOnce(1, 1'b0);
    runOnce(2, 1'b1);
    runOnce(1, 1'b1);
    finishRun();
  end

endmodule